// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block derives every digital drive waveform that a two-phase linear CCD sensor needs from one fast system clock. It produces two complementary transfer phases, a reset-gate pulse at the head of each pixel slot, and a transfer-gate pulse that moves the photo charge into the shift register. The interval between two transfer-gate pulses is the exposure time of one line.

For each pixel slot of the readout it emits a sample strobe, a slot index and a two-bit segment code. A downstream converter or capture stage uses these to decide which samples to keep. The frame is 2658 slots long and has five regions. It opens with 8 blank-feed slots, then 52 optically shielded black-reference slots, then 3 invalid slots. The 2592 image slots follow, and 3 more invalid slots close the frame.

Software-visible inputs set three things: the slot length in system clocks, the reset-gate width and the strobe offset. A fourth input sets the line length as a count of transfer periods. All four are captured at the start of each line, so that a line never changes shape while it is running.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is held, and afterwards until `enable` is seen high, `ph1`=1, `ph2`=0, `rg_pulse`=0, `xfer_gate`=0, `smp_stb`=0, `line_start`=0, `frame_done`=0, `pix_idx`=0 and `seg_code`=0.
- R2: Each line opens with a gate window of SG_SETUP+SG_WIDTH+SG_HOLD clocks in which `ph1`=1 and `ph2`=0. Inside that window, `xfer_gate` is high for exactly SG_WIDTH clocks, beginning SG_SETUP clocks after the window opens. `line_start` is high for one clock, on the first clock of the gate pulse.
- R3: After the window comes the readout, made of slots of T clocks each. Slot s drives `ph1`=1 and `ph2`=0 when s is even, and `ph1`=0 and `ph2`=1 when s is odd. The two phases are never high together.
- R4: `rg_pulse` is high for the first RW clocks of every readout slot. RW is `rst_width`, with two corrections: a value of 0 is used as 1, and a value with 2·RW ≥ T is replaced by (T−1)/2, rounded down.
- R5: T is `pix_div`, except that any value below 4 is used as 4.
- R6: For every slot s < 2658, `smp_stb` pulses once, on clock min(RW+`smp_ofs`, T−1) of the slot, counting from 0. Slots at or beyond 2658 produce no strobe. During readout, `pix_idx` shows the current slot, held at 2657 once the slot passes 2657. Outside readout it shows 0.
- R7: `seg_code` decodes `pix_idx` as follows: 0 for blank (0–7), 1 for black reference (8–59), 2 for invalid (60–62 and 2655–2657), and 3 for valid (63–2654).
- R8: A line has 2·N readout slots. N is `int_len`, but any value of 1330 or less is used as 1331. The time between consecutive `xfer_gate` rises is therefore window + 2·N·T clocks, which is more than 1330 transfer periods.
- R9: `frame_done` is high for one clock: the first clock of slot 2658.
- R10: The four configuration inputs are captured when a gate window opens, so a change made during a line takes effect only at the next line. If `enable` is low at the end of the last slot, the block returns to the R1 idle state instead of starting a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Starts lines; sampled when idle and at the end of each line |
| pix_div | input | DIV_W | Slot length T in system clocks |
| rst_width | input | DIV_W | Reset-gate width in system clocks |
| smp_ofs | input | DIV_W | Strobe offset after the end of the reset gate |
| int_len | input | INT_W | Line length in transfer periods |
| ph1 | output | 1 | Transfer phase 1 |
| ph2 | output | 1 | Transfer phase 2 |
| rg_pulse | output | 1 | Reset-gate pulse |
| xfer_gate | output | 1 | Transfer-gate (shift) pulse |
| smp_stb | output | 1 | Sample strobe, one per frame slot |
| pix_idx | output | 12 | Slot index |
| seg_code | output | 2 | Segment code of `pix_idx` |
| line_start | output | 1 | First clock of each transfer-gate pulse |
| frame_done | output | 1 | First clock after the last frame slot |

## Verification
The hardest situations to reach from the ports all sit at line boundaries. They are the clamps at their edges (period 2, width 0, length 1330 against 1331), a configuration change that arrives while a line is running, and `enable` falling so that the last slot ends in idle rather than in a new gate window. The stimulus runs four complete lines back to back and reprograms the inputs in the middle of each line. This shows at the port whether the old or the new settings governed the line. The last line is run with `enable` dropped partway through, and the idle levels are checked after it finishes. A behavioural reference model follows every clock across all of these transitions.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    // Frame layout, in slots
    localparam int N_BLANK = 8;
    localparam int N_BLACK = 52;
    localparam int N_INV   = 3;
    localparam int N_VALID = 2592;

    localparam int OFS_BLACK = N_BLANK;
    localparam int OFS_INV0  = OFS_BLACK + N_BLACK;
    localparam int OFS_VALID = OFS_INV0 + N_INV;
    localparam int OFS_INV1  = OFS_VALID + N_VALID;
    localparam int SLOTS     = OFS_INV1 + N_INV;
    localparam int SLOT_W    = $clog2(SLOTS);

    // Shortest line, in transfer periods
    localparam int MIN_PER = 1331;
    // Shortest slot, in system clocks
    localparam int MIN_T   = 4;

    typedef enum logic [1:0] {
        SEG_BLANK   = 2'd0,
        SEG_BLACK   = 2'd1,
        SEG_INVALID = 2'd2,
        SEG_VALID   = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIN  = 2'd1,
        ST_READ = 2'd2
    } st_e;

    localparam int NREG = 5;
    localparam int REG_LO [NREG] = '{0, OFS_BLACK, OFS_INV0, OFS_VALID, OFS_INV1};
    localparam int REG_HI [NREG] = '{OFS_BLACK - 1, OFS_INV0 - 1, OFS_VALID - 1,
                                     OFS_INV1 - 1, SLOTS - 1};
    localparam seg_e REG_CODE [NREG] = '{SEG_BLANK, SEG_BLACK, SEG_INVALID,
                                         SEG_VALID, SEG_INVALID};

endpackage

// File: rtl/ccd_cfg_clamp.sv
module ccd_cfg_clamp
    import ccd_tg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int INT_W = 16
) (
    input  logic [DIV_W-1:0] pix_div,
    input  logic [DIV_W-1:0] rst_width,
    input  logic [DIV_W-1:0] smp_ofs,
    input  logic [INT_W-1:0] int_len,
    output logic [DIV_W-1:0] t_eff,
    output logic [DIV_W-1:0] rw_eff,
    output logic [DIV_W-1:0] sp_eff,
    output logic [INT_W-1:0] n_eff
);

    logic [DIV_W-1:0] rw_raw;
    logic [DIV_W:0]   rw_dbl;
    logic [DIV_W:0]   sp_sum;

    always_comb begin
        // R5: slot length floor
        t_eff  = (pix_div < DIV_W'(MIN_T)) ? DIV_W'(MIN_T) : pix_div;

        // R4: reset-gate width, nonzero and under half a slot
        rw_raw = (rst_width == '0) ? DIV_W'(1) : rst_width;
        rw_dbl = {rw_raw, 1'b0};
        rw_eff = (rw_dbl >= {1'b0, t_eff}) ? ((t_eff - DIV_W'(1)) >> 1) : rw_raw;

        // R6: strobe position kept inside the slot
        sp_sum = {1'b0, rw_eff} + {1'b0, smp_ofs};
        sp_eff = (sp_sum >= {1'b0, t_eff}) ? (t_eff - DIV_W'(1)) : sp_sum[DIV_W-1:0];

        // R8: line length floor
        n_eff  = (int_len <= INT_W'(MIN_PER - 1)) ? INT_W'(MIN_PER) : int_len;
    end

endmodule

// File: rtl/ccd_seg_decode.sv
module ccd_seg_decode
    import ccd_tg_pkg::*;
(
    input  logic [SLOT_W-1:0] idx,
    output seg_e              seg
);

    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        assign hit[g] = (int'(idx) >= REG_LO[g]) && (int'(idx) <= REG_HI[g]);
    end

    // R7: region lookup
    always_comb begin
        seg = SEG_BLANK;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) seg = REG_CODE[i];
        end
    end

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_tg_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int INT_W    = 16,
    parameter int SG_SETUP = 3,
    parameter int SG_WIDTH = 50,
    parameter int SG_HOLD  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] pix_div,
    input  logic [DIV_W-1:0] rst_width,
    input  logic [DIV_W-1:0] smp_ofs,
    input  logic [INT_W-1:0] int_len,
    output logic             ph1,
    output logic             ph2,
    output logic             rg_pulse,
    output logic             xfer_gate,
    output logic             smp_stb,
    output logic [11:0]      pix_idx,
    output logic [1:0]       seg_code,
    output logic             line_start,
    output logic             frame_done
);

    localparam int SG_LEN  = SG_SETUP + SG_WIDTH + SG_HOLD;
    localparam int WIN_W   = $clog2(SG_LEN + 1);
    localparam int CNT_W   = (DIV_W > WIN_W) ? DIV_W : WIN_W;
    localparam int SLOTC_W = INT_W + 1;

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        logic [SLOTC_W-1:0] slot;
        logic [DIV_W-1:0] t;
        logic [DIV_W-1:0] rw;
        logic [DIV_W-1:0] sp;
        logic [INT_W-1:0] n;
    } ctl_t;

    typedef struct packed {
        logic        ph1;
        logic        ph2;
        logic        rg;
        logic        sg;
        logic        stb;
        logic [11:0] idx;
        seg_e        seg;
        logic        ls;
        logic        fd;
    } out_t;

    ctl_t ctl_d, ctl_q;
    out_t out_d, out_q;

    logic [DIV_W-1:0] t_c, rw_c, sp_c;
    logic [INT_W-1:0] n_c;
    logic [SLOT_W-1:0] idx_d;
    seg_e seg_d;

    ccd_cfg_clamp #(.DIV_W(DIV_W), .INT_W(INT_W)) u_clamp (
        .pix_div   (pix_div),
        .rst_width (rst_width),
        .smp_ofs   (smp_ofs),
        .int_len   (int_len),
        .t_eff     (t_c),
        .rw_eff    (rw_c),
        .sp_eff    (sp_c),
        .n_eff     (n_c)
    );

    // Sequencing: next control state
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (enable) begin
                    ctl_d.st  = ST_WIN;
                    ctl_d.cnt = '0;
                    ctl_d.t   = t_c;
                    ctl_d.rw  = rw_c;
                    ctl_d.sp  = sp_c;
                    ctl_d.n   = n_c;
                end
            end
            ST_WIN: begin
                if (ctl_q.cnt == CNT_W'(SG_LEN - 1)) begin
                    ctl_d.st   = ST_READ;
                    ctl_d.cnt  = '0;
                    ctl_d.slot = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            ST_READ: begin
                if (ctl_q.cnt == CNT_W'(ctl_q.t) - CNT_W'(1)) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.slot == SLOTC_W'({ctl_q.n, 1'b0}) - SLOTC_W'(1)) begin
                        ctl_d.slot = '0;
                        // R10: chain into the next line or fall back to idle
                        if (enable) begin
                            ctl_d.st = ST_WIN;
                            ctl_d.t  = t_c;
                            ctl_d.rw = rw_c;
                            ctl_d.sp = sp_c;
                            ctl_d.n  = n_c;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end else begin
                        ctl_d.slot = ctl_q.slot + SLOTC_W'(1);
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    // Slot index shown for the next cycle
    assign idx_d = (ctl_d.st != ST_READ)          ? '0 :
                   (ctl_d.slot < SLOTC_W'(SLOTS)) ? ctl_d.slot[SLOT_W-1:0] :
                                                    SLOT_W'(SLOTS - 1);

    ccd_seg_decode u_seg (
        .idx (idx_d),
        .seg (seg_d)
    );

    // Output decode from the next control state
    always_comb begin
        logic in_rd, in_win;
        in_rd  = (ctl_d.st == ST_READ);
        in_win = (ctl_d.st == ST_WIN);

        out_d.ph2 = in_rd && ctl_d.slot[0];
        out_d.ph1 = !out_d.ph2;
        out_d.rg  = in_rd && (ctl_d.cnt < CNT_W'(ctl_d.rw));
        out_d.sg  = in_win && (ctl_d.cnt >= CNT_W'(SG_SETUP))
                           && (ctl_d.cnt <  CNT_W'(SG_SETUP + SG_WIDTH));
        out_d.ls  = in_win && (ctl_d.cnt == CNT_W'(SG_SETUP));
        out_d.stb = in_rd && (ctl_d.slot < SLOTC_W'(SLOTS))
                          && (ctl_d.cnt == CNT_W'(ctl_d.sp));
        out_d.fd  = in_rd && (ctl_d.slot == SLOTC_W'(SLOTS)) && (ctl_d.cnt == '0);
        out_d.idx = 12'(idx_d);
        out_d.seg = seg_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, slot: '0, t: DIV_W'(MIN_T),
                       rw: DIV_W'(1), sp: DIV_W'(1), n: INT_W'(MIN_PER)};
            out_q <= '{ph1: 1'b1, ph2: 1'b0, rg: 1'b0, sg: 1'b0, stb: 1'b0,
                       idx: '0, seg: SEG_BLANK, ls: 1'b0, fd: 1'b0};
        end else begin
            ctl_q <= ctl_d;
            out_q <= out_d;
        end
    end

    assign ph1        = out_q.ph1;
    assign ph2        = out_q.ph2;
    assign rg_pulse   = out_q.rg;
    assign xfer_gate  = out_q.sg;
    assign smp_stb    = out_q.stb;
    assign pix_idx    = out_q.idx;
    assign seg_code   = out_q.seg;
    assign line_start = out_q.ls;
    assign frame_done = out_q.fd;

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        ph1,
    input logic        ph2,
    input logic        rg_pulse,
    input logic        xfer_gate,
    input logic        smp_stb,
    input logic [11:0] pix_idx,
    input logic        line_start,
    input logic        frame_done
);

    logic [15:0] p2_rises_q;
    logic        seen_q, ph2_prev_q, sg_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            p2_rises_q <= '0;
            seen_q     <= 1'b0;
            ph2_prev_q <= 1'b0;
            sg_prev_q  <= 1'b0;
        end else begin
            ph2_prev_q <= ph2;
            sg_prev_q  <= xfer_gate;
            if (xfer_gate && !sg_prev_q) begin
                seen_q     <= 1'b1;
                p2_rises_q <= '0;
            end else if (ph2 && !ph2_prev_q && p2_rises_q != 16'hFFFF) begin
                p2_rises_q <= p2_rises_q + 16'd1;
            end
        end
    end

    // R2: gate lies inside a held phase-1 interval
    p_gate_in_ph1_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_gate |-> (ph1 && !ph2));

    p_gate_setup_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_gate) |-> $past(ph1));

    p_gate_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_gate) |-> ph1);

    p_line_start_r2: assert property (@(posedge clk) disable iff (rst)
        line_start |-> $rose(xfer_gate));

    // R4: reset gate never overlaps the transfer gate
    p_rg_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        rg_pulse |-> !xfer_gate);

    // R6: strobe after the reset gate, index inside the frame
    p_stb_place_r6: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> (!rg_pulse && pix_idx < 12'd2658));

    // R8: enough transfer periods between gates
    p_min_periods_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer_gate && !sg_prev_q && seen_q) |-> (p2_rises_q >= 16'd1331));

    // R9: single-clock frame end flag
    p_fdone_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

bind ccd_line_timer ccd_line_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ph1        (ph1),
    .ph2        (ph2),
    .rg_pulse   (rg_pulse),
    .xfer_gate  (xfer_gate),
    .smp_stb    (smp_stb),
    .pix_idx    (pix_idx),
    .line_start (line_start),
    .frame_done (frame_done)
);

// File: tb/tb_ccd_line_timer.sv
module tb_ccd_line_timer;

    localparam int SETUP = 3, WIDTH = 50, HOLD = 3;
    localparam int WIN = SETUP + WIDTH + HOLD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [7:0]  pix_div = 8'd4, rst_width = 8'd1, smp_ofs = 8'd1;
    logic [15:0] int_len = 16'd100;
    logic        ph1, ph2, rg_pulse, xfer_gate, smp_stb, line_start, frame_done;
    logic [11:0] pix_idx;
    logic [1:0]  seg_code;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ccd_line_timer #(.DIV_W(8), .INT_W(16), .SG_SETUP(SETUP),
                     .SG_WIDTH(WIDTH), .SG_HOLD(HOLD)) dut (
        .clk(clk), .rst(rst), .enable(enable), .pix_div(pix_div),
        .rst_width(rst_width), .smp_ofs(smp_ofs), .int_len(int_len),
        .ph1(ph1), .ph2(ph2), .rg_pulse(rg_pulse), .xfer_gate(xfer_gate),
        .smp_stb(smp_stb), .pix_idx(pix_idx), .seg_code(seg_code),
        .line_start(line_start), .frame_done(frame_done));

    // ---------------- reference model ----------------
    int m_mode = 0, m_pos = 0, m_slot = 0;
    int m_t = 4, m_rw = 1, m_sp = 1, m_n = 1331;

    task automatic take_cfg();
        m_t  = (pix_div < 4) ? 4 : int'(pix_div);             // R5
        m_rw = (rst_width == 0) ? 1 : int'(rst_width);        // R4
        if (2 * m_rw >= m_t) m_rw = (m_t - 1) / 2;
        m_sp = m_rw + int'(smp_ofs);                          // R6
        if (m_sp > m_t - 1) m_sp = m_t - 1;
        m_n  = (int_len <= 1330) ? 1331 : int'(int_len);      // R8
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_pos = 0; m_slot = 0;
        end else begin
            case (m_mode)
                0: if (enable) begin m_mode = 1; m_pos = 0; take_cfg(); end
                1: if (m_pos == WIN - 1) begin m_mode = 2; m_pos = 0; m_slot = 0; end
                   else m_pos++;
                default: begin
                    if (m_pos == m_t - 1) begin
                        m_pos = 0;
                        if (m_slot == 2 * m_n - 1) begin
                            m_slot = 0;
                            if (enable) begin m_mode = 1; take_cfg(); end   // R10
                            else m_mode = 0;
                        end else m_slot++;
                    end else m_pos++;
                end
            endcase
        end
    end

    function automatic int seg_of(int i);
        if (i < 8)     return 0;   // R7 blank
        if (i < 60)    return 1;   // R7 black
        if (i < 63)    return 2;   // R7 invalid
        if (i < 2655)  return 3;   // R7 valid
        return 2;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        cmp(req, what, act, exp);
    endtask

    // per-cycle comparison, sampled on the falling edge
    always @(negedge clk) begin
        int e2, erg, esg, els, estb, efd, eidx;
        string rq;
        if (!finished) begin
            e2   = (m_mode == 2 && (m_slot % 2) == 1) ? 1 : 0;
            erg  = (m_mode == 2 && m_pos < m_rw) ? 1 : 0;
            esg  = (m_mode == 1 && m_pos >= SETUP && m_pos < SETUP + WIDTH) ? 1 : 0;
            els  = (m_mode == 1 && m_pos == SETUP) ? 1 : 0;
            estb = (m_mode == 2 && m_slot < 2658 && m_pos == m_sp) ? 1 : 0;
            efd  = (m_mode == 2 && m_slot == 2658 && m_pos == 0) ? 1 : 0;
            eidx = (m_mode != 2) ? 0 : (m_slot < 2658 ? m_slot : 2657);
            rq   = (m_mode == 0) ? "R1" : (m_mode == 1 ? "R2" : "R3");
            vectors++;
            cmp(rq,   "ph1",        int'(ph1),        1 - e2);
            cmp(rq,   "ph2",        int'(ph2),        e2);
            cmp("R4", "rg_pulse",   int'(rg_pulse),   erg);
            cmp("R2", "xfer_gate",  int'(xfer_gate),  esg);
            cmp("R2", "line_start", int'(line_start), els);
            cmp("R6", "smp_stb",    int'(smp_stb),    estb);
            cmp("R6", "pix_idx",    int'(pix_idx),    eidx);
            cmp("R7", "seg_code",   int'(seg_code),   seg_of(eidx));
            cmp("R9", "frame_done", int'(frame_done), efd);
        end
    end

    // ---------------- event counters ----------------
    int cyc = 0, ls_count = 0, stb_run = 0, fd_run = 0;
    int stb_last = -1, fd_last = -1;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (line_start) begin
            ls_count <= ls_count + 1;
            stb_last <= stb_run;
            fd_last  <= fd_run;
            stb_run  <= 0;
            fd_run   <= 0;
        end else begin
            stb_run <= stb_run + int'(smp_stb);
            fd_run  <= fd_run + int'(frame_done);
        end
    end

    task automatic wait_ls(output int at);
        do @(negedge clk); while (!line_start);
        at = cyc;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        int t1, t2, t3, t4, ls_before;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1", "ph1 in reset", int'(ph1), 1);
        check("R1", "xfer_gate in reset", int'(xfer_gate), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R1", "ph2 idle", int'(ph2), 0);
        check("R1", "rg_pulse idle", int'(rg_pulse), 0);

        // Line 1: period 4, length 100 -> floor 1331 (R8)
        enable = 1'b1;
        wait_ls(t1);
        repeat (200) @(negedge clk);
        // R10: reprogram mid-line; only line 2 may see it
        pix_div = 8'd6; rst_width = 8'd5; smp_ofs = 8'd10; int_len = 16'd1400;
        wait_ls(t2);
        @(negedge clk);
        check("R10", "line 1 span with mid-line change", t2 - t1, WIN + 2 * 1331 * 4);
        check("R6", "strobes in line 1", stb_last, 2658);
        check("R9", "frame_done pulses in line 1", fd_last, 1);

        // Line 3 config: period 2 -> 4 (R5), width 0 -> 1 (R4), 1330 -> 1331 (R8)
        pix_div = 8'd2; rst_width = 8'd0; smp_ofs = 8'd0; int_len = 16'd1330;
        wait_ls(t3);
        @(negedge clk);
        check("R8", "line 2 span, T=6 N=1400", t3 - t2, WIN + 2 * 1400 * 6);
        check("R6", "strobes in line 2", stb_last, 2658);

        pix_div = 8'd5; rst_width = 8'd2; smp_ofs = 8'd1; int_len = 16'd1331;
        wait_ls(t4);
        @(negedge clk);
        check("R5", "line 3 span, period clamped to 4", t4 - t3, WIN + 2 * 1331 * 4);
        check("R9", "frame_done pulses in line 3", fd_last, 1);

        // R10: drop enable in line 4, expect idle afterwards
        repeat (100) @(negedge clk);
        enable = 1'b0;
        ls_before = ls_count;
        repeat (2 * 1331 * 5 + 100) @(negedge clk);
        check("R10", "no new line after enable low", ls_count, ls_before);
        check("R10", "ph1 idle after line", int'(ph1), 1);
        check("R10", "ph2 idle after line", int'(ph2), 0);
        check("R10", "xfer_gate idle after line", int'(xfer_gate), 0);
        check("R10", "pix_idx idle after line", int'(pix_idx), 0);
        finish_run();
    end

endmodule